// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block is the transmit half of an asynchronous serial channel. Software, or a nearby controller, loads three things through a single write port: a mode word that sets the character format, a control word that gates the transmitter, and characters. Characters go into a 16-entry queue. The block turns each queued character into a serial frame on its TX line and advances by one bit each time the external baud enable pulses for one cycle.

The frame format is chosen per frame. It covers 6, 7 or 8 data bits, five parity choices (even, odd, forced-low, forced-high, or no parity bit) and one or two stop bits. Separate control bits enable and disable the transmitter, start and stop a break, and clear the channel. A loopback mode turns the serial stream inward onto a receive monitor output, and the external TX line then rests high.

The write selector picks the target: `wr_sel` = 0 is the mode word, 1 is the control word, 2 is the character queue (`wr_data[7:0]`), and 3 is ignored.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, `txd` is high, `fifo_empty` is 1 and `fifo_full` is 0. The transmitter is disabled, so a queued character is not sent. The mode word resets to 8 data bits, no parity and one stop bit (value 0x020).
- R2: A frame is a low start bit, then the data bits least significant first, then the parity bit if one is present, then one or two high stop bits. The line changes only on a clock edge where `baud_tick` is 1, one bit per tick.
- R3: Mode bits [2:1] set the character length: 00 and 01 give 8 data bits, 10 gives 7 and 11 gives 6.
- R4: Mode bits [5:3] set the parity bit: 000 makes the count of ones over data and parity even, 001 makes it odd, 010 sends 0, 011 sends 1, and 1xx sends no parity bit.
- R5: Mode bit 7 set to 0 gives one stop bit; set to 1 it gives two.
- R6: Control bit 4 enables the transmitter and control bit 5 disables it; when both are written together, disable wins. A disabled transmitter finishes the frame in flight but starts no new one.
- R7: Control bit 1 acts on the cycle after the write. It empties the queue, abandons the frame in flight and returns the line to high. It does not stay set, so later characters are sent normally.
- R8: Control bit 7 starts a break and control bit 8 stops it; when both are written together, stop wins. During a break the line is low and no frame starts. Queued characters wait until the break is stopped.
- R9: The queue holds 16 characters. `fifo_full` is 1 at 16 entries and `fifo_empty` is 1 at 0 entries. A character written while the queue is full is dropped.
- R10: The format fields of the mode word are captured when a frame starts, so a mode write during a frame affects only the frames that follow.
- R11: With mode bits [9:8] = 10, `txd` stays high and `rx_mon` carries the serial stream. Otherwise `rx_mon` follows `rxd`.
- R12: When the queue is not empty, the next start bit goes out on the tick right after the last stop bit, with no idle bit between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 mode, 1 control, 2 character, 3 none |
| wr_data | input | 10 | Write data |
| baud_tick | input | 1 | One-cycle bit-rate enable |
| rxd | input | 1 | External receive line, passed to `rx_mon` outside loopback |
| txd | output | 1 | Serial transmit line |
| rx_mon | output | 1 | Receive-path monitor (serial stream in loopback) |
| fifo_empty | output | 1 | Queue holds no characters |
| fifo_full | output | 1 | Queue holds 16 characters |

## Verification
The assertions assume that `baud_tick` is a single-cycle pulse and that the queue is popped only on such a pulse. With that assumption, a full queue with no tick and no clear pending must stay full, and the serial bit must hold between ticks. They also assume that a clear caused by control bit 1 takes priority over a character write made in the same cycle. The stimulus keeps to these assumptions. Each tick is one cycle wide with an idle cycle after it. Writes and ticks never fall in the same cycle. Clear commands are issued only after all character writes have finished.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int REG_W   = 10;
    localparam int DATA_W  = 8;
    localparam int FRAME_W = 12;                 // start + 8 data + parity + 2 stop
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    // control word bit positions
    localparam int CB_FLUSH   = 1;
    localparam int CB_EN      = 4;
    localparam int CB_DIS     = 5;
    localparam int CB_BRK_SET = 7;
    localparam int CB_BRK_CLR = 8;

    localparam logic [REG_W-1:0] MODE_RST = 10'h020;

    typedef enum logic [1:0] {
        SEL_MODE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_CHAR = 2'd2,
        SEL_NONE = 2'd3
    } wr_sel_e;

    typedef enum logic [1:0] {
        CH_NORMAL = 2'b00,
        CH_LOCAL  = 2'b10
    } chan_e;

    typedef struct packed {
        logic [1:0] chmode;
        logic       two_stop;
        logic [2:0] parity;
        logic [1:0] charlen;
    } mode_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [LEN_W-1:0]   len;
    } frame_t;

    function automatic mode_t unpack_mode(input logic [REG_W-1:0] w);
        mode_t m;
        m.chmode   = w[9:8];
        m.two_stop = w[7];
        m.parity   = w[5:3];
        m.charlen  = w[2:1];
        return m;
    endfunction

    function automatic frame_t build_frame(input logic [DATA_W-1:0] ch, input mode_t m);
        frame_t             f;
        logic [DATA_W-1:0]  dmask;
        logic [LEN_W-1:0]   nb;
        logic [LEN_W-1:0]   pos;
        logic [FRAME_W-1:0] acc;
        logic               pbit;
        case (m.charlen)
            2'b10:   begin dmask = 8'h7F; nb = LEN_W'(7); end
            2'b11:   begin dmask = 8'h3F; nb = LEN_W'(6); end
            default: begin dmask = 8'hFF; nb = LEN_W'(8); end
        endcase
        pos = nb + LEN_W'(1);
        acc = ({FRAME_W{1'b1}} << pos) | (FRAME_W'(ch & dmask) << 1);
        case (m.parity[1:0])
            2'b00:   pbit = ^(ch & dmask);
            2'b01:   pbit = ~^(ch & dmask);
            2'b10:   pbit = 1'b0;
            default: pbit = 1'b1;
        endcase
        if (!m.parity[2]) begin
            acc = (acc & ~(FRAME_W'(1) << pos)) | (FRAME_W'(pbit) << pos);
            pos = pos + LEN_W'(1);
        end
        f.bits = acc;
        f.len  = pos + (m.two_stop ? LEN_W'(2) : LEN_W'(1));
        return f;
    endfunction

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [AW:0]   count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == (AW+1)'(DEPTH));
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
            case ({do_push, do_pop})
                2'b10:   count <= count + (AW+1)'(1);
                2'b01:   count <= count - (AW+1)'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
    import uart_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output mode_t            mode,
    output logic             tx_en,
    output logic             brk_on,
    output logic             soft_rst,
    output logic             char_push
);
    logic wr_mode, wr_ctrl;

    assign wr_mode   = wr_en && (wr_sel_e'(wr_sel) == SEL_MODE);
    assign wr_ctrl   = wr_en && (wr_sel_e'(wr_sel) == SEL_CTRL);
    assign char_push = wr_en && (wr_sel_e'(wr_sel) == SEL_CHAR);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= unpack_mode(MODE_RST);
            tx_en    <= 1'b0;
            brk_on   <= 1'b0;
            soft_rst <= 1'b0;
        end else begin
            soft_rst <= wr_ctrl && wr_data[CB_FLUSH];
            if (wr_mode) mode <= unpack_mode(wr_data);
            if (wr_ctrl) begin
                if (wr_data[CB_DIS])     tx_en <= 1'b0;
                else if (wr_data[CB_EN]) tx_en <= 1'b1;
                if (wr_data[CB_BRK_CLR])      brk_on <= 1'b0;
                else if (wr_data[CB_BRK_SET]) brk_on <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
    import uart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              baud_tick,
    input  logic              tx_en,
    input  logic              brk_on,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_rdata,
    input  mode_t             mode,
    output logic              pop,
    output logic              serial_bit,
    output logic              busy
);
    logic [FRAME_W-1:0] shreg;
    logic [LEN_W-1:0]   remain;
    logic               at_boundary, can_start;
    frame_t             next_frame;

    assign at_boundary = !busy || (remain == LEN_W'(1));
    assign can_start   = tx_en && !brk_on && !fifo_empty;
    assign pop         = baud_tick && at_boundary && can_start && !flush;
    assign next_frame  = build_frame(fifo_rdata, mode);
    assign serial_bit  = shreg[0];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            shreg  <= '1;
            remain <= '0;
            busy   <= 1'b0;
        end else if (baud_tick) begin
            if (at_boundary) begin
                if (can_start) begin
                    shreg  <= next_frame.bits;
                    remain <= next_frame.len;
                    busy   <= 1'b1;
                end else begin
                    shreg  <= '1;
                    remain <= '0;
                    busy   <= 1'b0;
                end
            end else begin
                shreg  <= {1'b1, shreg[FRAME_W-1:1]};
                remain <= remain - LEN_W'(1);
            end
        end
    end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             baud_tick,
    input  logic             rxd,
    output logic             txd,
    output logic             rx_mon,
    output logic             fifo_empty,
    output logic             fifo_full
);
    mode_t             mode_q;
    logic              tx_en_q, brk_q, soft_rst_w, push_w, pop_w;
    logic              ser_bit, ser_busy, line_w, loop_w;
    logic [DATA_W-1:0] head_char;

    uart_tx_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .mode      (mode_q),
        .tx_en     (tx_en_q),
        .brk_on    (brk_q),
        .soft_rst  (soft_rst_w),
        .char_push (push_w)
    );

    uart_tx_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (soft_rst_w),
        .push  (push_w),
        .wdata (wr_data[DATA_W-1:0]),
        .pop   (pop_w),
        .rdata (head_char),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    uart_tx_serializer u_ser (
        .clk        (clk),
        .rst        (rst),
        .flush      (soft_rst_w),
        .baud_tick  (baud_tick),
        .tx_en      (tx_en_q),
        .brk_on     (brk_q),
        .fifo_empty (fifo_empty),
        .fifo_rdata (head_char),
        .mode       (mode_q),
        .pop        (pop_w),
        .serial_bit (ser_bit),
        .busy       (ser_busy)
    );

    assign line_w = brk_q ? 1'b0 : ser_bit;
    assign loop_w = (chan_e'(mode_q.chmode) == CH_LOCAL);
    assign txd    = loop_w ? 1'b1 : line_w;
    assign rx_mon = loop_w ? line_w : rxd;
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
    input logic clk,
    input logic rst,
    input logic baud_tick,
    input logic fifo_empty,
    input logic fifo_full,
    input logic soft_rst,
    input logic ser_busy,
    input logic tx_en,
    input logic brk_on,
    input logic serial_bit
);
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(fifo_empty && fifo_full)); // R9

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        fifo_full && !baud_tick && !soft_rst |=> fifo_full); // R9

    AST_BIT_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        !baud_tick && !soft_rst |=> $stable(serial_bit)); // R2

    AST_START_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_busy) |-> $past(tx_en) && !$past(brk_on)); // R6

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> fifo_empty && !ser_busy); // R7
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .baud_tick  (baud_tick),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .soft_rst   (soft_rst_w),
    .ser_busy   (ser_busy),
    .tx_en      (tx_en_q),
    .brk_on     (brk_q),
    .serial_bit (ser_bit)
);

// File: tb/uart_frame_tx_tb.sv
module uart_frame_tx_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [9:0] wr_data = '0;
    logic       baud_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       txd, rx_mon, fifo_empty, fifo_full;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_frame_tx u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .baud_tick(baud_tick), .rxd(rxd), .txd(txd), .rx_mon(rx_mon),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [9:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick(output logic t, output logic m);
        @(negedge clk);
        baud_tick = 1'b1;
        @(negedge clk);
        baud_tick = 1'b0;
        t = txd;
        m = rx_mon;
    endtask

    task automatic recv(input int len, input int first, input logic use_mon,
                        inout logic [11:0] v, output logic txd_all_high);
        logic t, m;
        txd_all_high = 1'b1;
        for (int i = first; i < len; i++) begin
            tick(t, m);
            v[i] = use_mon ? m : t;
            txd_all_high &= t;
        end
    endtask

    function automatic logic [11:0] exp_frame(input logic [7:0] d, input int nbits,
                                              input int par, input int stops, output int len);
        logic [11:0] v = '1;
        int ones = 0;
        int pos;
        v[0] = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            v[1+i] = d[i];
            ones += int'(d[i]);
        end
        pos = 1 + nbits;
        if (par < 4) begin
            case (par)
                0: v[pos] = (ones % 2) == 1;
                1: v[pos] = (ones % 2) == 0;
                2: v[pos] = 1'b0;
                default: v[pos] = 1'b1;
            endcase
            pos++;
        end
        len = pos + stops;
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic t, m, hi;
        logic [11:0] got, ef;
        int len, len2;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk(txd == 1'b1, "R1 txd idle", 32'(txd), 1);
        chk(fifo_empty == 1'b1 && fifo_full == 1'b0, "R1 flags", {fifo_full, fifo_empty}, 2'b01);
        wr(2'd2, 10'h0AA);
        hi = 1'b1;
        for (int i = 0; i < 3; i++) begin tick(t, m); hi &= t; end
        chk(hi && !fifo_empty, "R1 disabled after reset", {hi, fifo_empty}, 2'b10);
        wr(2'd1, 10'h002);
        @(negedge clk);
        wr(2'd1, 10'h010);

        // R2 R3 R4 R5 R12: sweep of every format, two back-to-back frames each
        for (int li = 0; li < 3; li++) begin
            for (int p = 0; p < 5; p++) begin
                for (int s = 0; s < 2; s++) begin
                    int cfg = li*10 + p*2 + s;
                    int nb = (li == 0) ? 8 : (li == 1) ? 7 : 6;
                    logic [1:0] lc = (li == 0) ? 2'b00 : (li == 1) ? 2'b10 : 2'b11;
                    logic [7:0] d0 = 8'((cfg*53 + 17) & 255);
                    logic [7:0] d1 = ~d0 ^ 8'(cfg);
                    wr(2'd0, {2'b00, s[0], 1'b0, p[2:0], lc, 1'b0});
                    wr(2'd2, {2'b00, d0});
                    wr(2'd2, {2'b00, d1});
                    got = '1;
                    ef = exp_frame(d0, nb, p, s + 1, len);
                    recv(len, 0, 1'b0, got, hi);
                    chk(got == ef, "R2 R3 R4 R5 first frame", got, ef);
                    got = '1;
                    ef = exp_frame(d1, nb, p, s + 1, len);
                    recv(len, 0, 1'b0, got, hi);
                    chk(got == ef, "R12 R3 R4 R5 second frame back to back", got, ef);
                    tick(t, m);
                    chk(t == 1'b1, "R2 idle after frames", 32'(t), 1);
                end
            end
        end

        // R10: mode written mid-frame applies to the next frame
        wr(2'd0, 10'h020);
        wr(2'd2, 10'h03C);
        got = '1;
        tick(t, m);
        got[0] = t;
        wr(2'd0, 10'h088);
        wr(2'd2, 10'h0C3);
        ef = exp_frame(8'h3C, 8, 4, 1, len);
        recv(len, 1, 1'b0, got, hi);
        chk(got == ef, "R10 frame keeps old mode", got, ef);
        got = '1;
        ef = exp_frame(8'hC3, 8, 1, 2, len);
        recv(len, 0, 1'b0, got, hi);
        chk(got == ef, "R10 next frame uses new mode", got, ef);
        wr(2'd0, 10'h020);

        // R9: depth, flags and drop on full
        wr(2'd1, 10'h020);
        for (int i = 0; i < 15; i++) wr(2'd2, 10'(8'h10 + i));
        chk(!fifo_full && !fifo_empty, "R9 fifteen entries", {fifo_full, fifo_empty}, 2'b00);
        wr(2'd2, 10'h01F);
        chk(fifo_full == 1'b1, "R9 full at sixteen", 32'(fifo_full), 1);
        wr(2'd2, 10'h0FF);
        wr(2'd1, 10'h010);
        for (int i = 0; i < 16; i++) begin
            got = '1;
            ef = exp_frame(8'(8'h10 + i), 8, 4, 1, len);
            recv(len, 0, 1'b0, got, hi);
            chk(got == ef, "R9 drained character", got, ef);
        end
        tick(t, m);
        chk(t == 1'b1 && fifo_empty, "R9 write while full dropped", {t, fifo_empty}, 2'b11);

        // R6: disable wins over enable; disable lets frame finish
        wr(2'd1, 10'h030);
        wr(2'd2, 10'h055);
        hi = 1'b1;
        for (int i = 0; i < 3; i++) begin tick(t, m); hi &= t; end
        chk(hi == 1'b1, "R6 both bits leave disabled", 32'(hi), 1);
        wr(2'd1, 10'h010);
        got = '1;
        ef = exp_frame(8'h55, 8, 4, 1, len);
        recv(len, 0, 1'b0, got, hi);
        chk(got == ef, "R6 sends once enabled", got, ef);
        wr(2'd2, 10'h011);
        wr(2'd2, 10'h022);
        got = '1;
        tick(t, m);
        got[0] = t;
        wr(2'd1, 10'h020);
        ef = exp_frame(8'h11, 8, 4, 1, len);
        recv(len, 1, 1'b0, got, hi);
        chk(got == ef, "R6 frame in flight completes", got, ef);
        tick(t, m);
        chk(t == 1'b1 && !fifo_empty, "R6 no new frame when disabled", {t, fifo_empty}, 2'b10);

        // R7: soft clear flushes and aborts, and is not sticky
        wr(2'd1, 10'h012);
        @(negedge clk);
        chk(fifo_empty == 1'b1, "R7 flush while idle", 32'(fifo_empty), 1);
        wr(2'd2, 10'h0A5);
        wr(2'd2, 10'h05A);
        tick(t, m);
        chk(t == 1'b0, "R7 start bit before clear", 32'(t), 0);
        wr(2'd1, 10'h012);
        @(negedge clk);
        chk(txd == 1'b1 && fifo_empty, "R7 aborted and flushed", {txd, fifo_empty}, 2'b11);
        tick(t, m);
        chk(t == 1'b1, "R7 idle after clear", 32'(t), 1);
        wr(2'd2, 10'h00F);
        got = '1;
        ef = exp_frame(8'h0F, 8, 4, 1, len);
        recv(len, 0, 1'b0, got, hi);
        chk(got == ef, "R7 clear not retained", got, ef);

        // R8: break start, hold, stop; stop wins
        wr(2'd1, 10'h090);
        chk(txd == 1'b0, "R8 break drives low", 32'(txd), 0);
        wr(2'd2, 10'h081);
        hi = 1'b0;
        for (int i = 0; i < 4; i++) begin tick(t, m); hi |= t; end
        chk(hi == 1'b0 && !fifo_empty, "R8 held low, character waits", {hi, fifo_empty}, 2'b00);
        wr(2'd1, 10'h100);
        chk(txd == 1'b1, "R8 break stopped", 32'(txd), 1);
        got = '1;
        ef = exp_frame(8'h81, 8, 4, 1, len);
        recv(len, 0, 1'b0, got, hi);
        chk(got == ef, "R8 queued character after break", got, ef);
        wr(2'd1, 10'h180);
        chk(txd == 1'b1, "R8 stop wins over start", 32'(txd), 1);

        // R11: local loopback and pass-through
        wr(2'd0, 10'h220);
        wr(2'd2, 10'h096);
        got = '1;
        ef = exp_frame(8'h96, 8, 4, 1, len2);
        recv(len2, 0, 1'b1, got, hi);
        chk(got == ef, "R11 loopback frame on rx_mon", got, ef);
        chk(hi == 1'b1, "R11 txd high in loopback", 32'(hi), 1);
        wr(2'd0, 10'h020);
        rxd = 1'b0;
        @(negedge clk);
        chk(rx_mon == 1'b0, "R11 rx_mon follows rxd low", 32'(rx_mon), 0);
        rxd = 1'b1;
        @(negedge clk);
        chk(rx_mon == 1'b1, "R11 rx_mon follows rxd high", 32'(rx_mon), 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule